// File: doc/BRIEF.md
# Serial DAC Input Frame Receiver

This block receives write frames for a 16-bit DAC over a three-wire serial link and holds the DAC code. The link has an active-low frame sync, a serial clock and a data line. A faster system clock samples all three wires. Each wire passes through its own synchroniser, and the block then finds the edges of the sampled signals. While sync is low, every falling edge of the serial clock shifts one data bit into a 24-bit frame register.

The code and power-mode registers change only when the 24th falling edge of a frame completes. If sync returns high before that edge, the partial frame is dropped and a one-cycle abort flag is raised. Serial clock edges that arrive after the 24th edge are ignored. Reset puts the code at midscale, which is code 0 for two's-complement data, and puts the power mode at normal.

Top module: `dac_frame_rx`

## Requirements
- R1: After reset, `dacCode` is 16'h0000 (two's-complement midscale), `pwrMode` is 2'b00, and neither `updateStb` nor `abortStb` is asserted.
- R2: A frame is 24 bits, most significant bit first. Frame bits 15:0 become `dacCode` and frame bits 17:16 become `pwrMode` (00 = normal, 01/10/11 = power-down variants). Frame bits 23:18 have no effect.
- R3: `dacCode` and `pwrMode` change only when the 24th falling serial clock edge of a frame completes. Each such frame raises `updateStb` for exactly one system clock cycle.
- R4: If sync rises after a frame has started and before its 24th falling edge, `dacCode` and `pwrMode` keep their previous values, no update strobe is raised, and `abortStb` is high for exactly one cycle.
- R5: Falling serial clock edges after the 24th edge and before sync rises are ignored. They cause no second update, and the bit count stays at 24.
- R6: Serial clock edges while sync is high shift nothing. They change no output and raise no strobe.
- R7: A falling edge of sync starts a new frame from bit zero, so a complete frame that follows an aborted one commits its own data correctly.
- R8: `updateStb` and `abortStb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| syncN | input | 1 | Active-low frame sync from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data; sampled on falling sclk edges |
| dacCode | output | 16 | Committed two's-complement DAC code |
| pwrMode | output | 2 | Committed power mode field |
| updateStb | output | 1 | One-cycle pulse when a frame commits |
| abortStb | output | 1 | One-cycle pulse when a frame is abandoned early |

## Verification
The assertions assume that each serial clock level lasts several system clock cycles. They also assume that `din` is stable around each falling edge, and that sync never changes in the same system clock cycle as a serial clock edge. Without these conditions, edges that were synchronised separately could be seen in the wrong order. The bench drives every input on the falling system clock edge. It holds each serial clock phase for four system clock cycles, changes data only while the serial clock is high, and leaves a full phase between any sync change and the nearest serial clock edge.

// File: rtl/dacrx_pkg.sv
package dacrx_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic clear;   // new frame: empty the shift register
    logic shift;   // capture one data bit
    logic commit;  // this shift is the final bit: load the outputs
  } frameStrobes_t;
endpackage

// File: rtl/dacrx_ctrl.sv
module dacrx_ctrl
  import dacrx_pkg::*;
#(
  parameter int FRAME_BITS  = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          syncN,
  input  logic          sclk,
  input  logic          din,
  output frameStrobes_t strobes,
  output logic          dinBit,
  output logic          abortStb
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam int N_IN = 3;
  // Idle levels: sync high, sclk high, data low
  localparam logic [N_IN-1:0] IDLE_LVL = 3'b110;

  logic [N_IN-1:0] rawIn, syncedIn;
  assign rawIn = {syncN, sclk, din};

  for (genvar g = 0; g < N_IN; g++) begin : gSync
    logic [SYNC_STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= {SYNC_STAGES{IDLE_LVL[g]}};
      else       pipe <= {pipe[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncedIn[g] = pipe[SYNC_STAGES-1];
  end

  logic syncS, sclkS;
  assign syncS  = syncedIn[2];
  assign sclkS  = syncedIn[1];
  assign dinBit = syncedIn[0];

  logic syncPrev, sclkPrev, frameActive;
  logic [CNT_W-1:0] bitCount;

  logic syncFall, syncRise, sclkFall, frameDone;
  assign syncFall  = syncPrev & ~syncS;
  assign syncRise  = ~syncPrev & syncS;
  assign sclkFall  = sclkPrev & ~sclkS;
  assign frameDone = (bitCount == CNT_W'(FRAME_BITS));

  always_comb begin
    strobes.clear  = syncFall;
    strobes.shift  = frameActive & ~syncS & sclkFall & ~frameDone;
    strobes.commit = strobes.shift & (bitCount == CNT_W'(FRAME_BITS - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev    <= 1'b1;
      sclkPrev    <= 1'b1;
      frameActive <= 1'b0;
      bitCount    <= '0;
      abortStb    <= 1'b0;
    end else begin
      syncPrev <= syncS;
      sclkPrev <= sclkS;
      abortStb <= syncRise & frameActive & ~frameDone;
      if (syncFall) begin
        frameActive <= 1'b1;
        bitCount    <= '0;
      end else begin
        if (syncRise) frameActive <= 1'b0;
        if (strobes.shift) bitCount <= bitCount + 1'b1;
      end
    end
  end

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= CNT_W'(FRAME_BITS));  // R5
  AST_SATURATED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !syncFall) |=> (bitCount == CNT_W'(FRAME_BITS)) || $past(syncFall));  // R5
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    abortStb |=> !abortStb);  // R4
  AST_COMMIT_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> frameActive && !syncS);  // R3
  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    syncS |-> !strobes.shift);  // R6
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.commit && abortStb));  // R8
endmodule

// File: rtl/dacrx_dp.sv
module dacrx_dp
  import dacrx_pkg::*;
#(
  parameter int FRAME_BITS = 24,
  parameter int CODE_BITS  = 16,
  parameter int MODE_BITS  = 2,
  parameter bit TWOS_COMP  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  frameStrobes_t        strobes,
  input  logic                 dinBit,
  output logic [CODE_BITS-1:0] dacCode,
  output logic [MODE_BITS-1:0] pwrMode,
  output logic                 updateStb
);
  // Midscale depends on the coding: 0 in two's complement, half range in offset binary
  localparam logic [CODE_BITS-1:0] MID_CODE =
    TWOS_COMP ? '0 : CODE_BITS'(1) << (CODE_BITS - 1);

  logic [FRAME_BITS-1:0] shiftReg, nextShift;
  assign nextShift = {shiftReg[FRAME_BITS-2:0], dinBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      dacCode   <= MID_CODE;
      pwrMode   <= '0;
      updateStb <= 1'b0;
    end else begin
      updateStb <= strobes.commit;
      if (strobes.clear)      shiftReg <= '0;
      else if (strobes.shift) shiftReg <= nextShift;
      if (strobes.commit) begin
        dacCode <= nextShift[CODE_BITS-1:0];
        pwrMode <= nextShift[CODE_BITS +: MODE_BITS];
      end
    end
  end

  AST_HOLD_CODE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(dacCode) && $stable(pwrMode));  // R4
  AST_UPDATE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    updateStb |=> !updateStb);  // R3
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
  import dacrx_pkg::*;
#(
  parameter int FRAME_BITS  = 24,
  parameter int CODE_BITS   = 16,
  parameter int MODE_BITS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 syncN,
  input  logic                 sclk,
  input  logic                 din,
  output logic [CODE_BITS-1:0] dacCode,
  output logic [MODE_BITS-1:0] pwrMode,
  output logic                 updateStb,
  output logic                 abortStb
);
  frameStrobes_t strobes;
  logic dinBit;

  dacrx_ctrl #(.FRAME_BITS(FRAME_BITS), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .syncN(syncN), .sclk(sclk), .din(din),
    .strobes(strobes), .dinBit(dinBit), .abortStb(abortStb)
  );

  dacrx_dp #(.FRAME_BITS(FRAME_BITS), .CODE_BITS(CODE_BITS),
             .MODE_BITS(MODE_BITS), .TWOS_COMP(1'b1)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dinBit(dinBit),
    .dacCode(dacCode), .pwrMode(pwrMode), .updateStb(updateStb)
  );

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rstN)
    !(updateStb && abortStb));  // R8
endmodule

// File: tb/test_dac_frame_rx.sv
module test_dac_frame_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncN = 1'b1, sclk = 1'b1, din = 1'b0;
  logic [15:0] dacCode;
  logic [1:0] pwrMode;
  logic updateStb, abortStb;

  int checks = 0, errors = 0;
  int updCnt = 0, abtCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dac_frame_rx i_dac_frame_rx (
    .clk(clk), .rstN(rstN), .syncN(syncN), .sclk(sclk), .din(din),
    .dacCode(dacCode), .pwrMode(pwrMode), .updateStb(updateStb), .abortStb(abortStb)
  );

  // frame, expected code, expected mode
  localparam int NVEC = 6;
  localparam logic [41:0] VEC [NVEC] = '{
    {24'h00FFFF, 16'hFFFF, 2'd0},
    {24'h017FFF, 16'h7FFF, 2'd1},
    {24'h028000, 16'h8000, 2'd2},
    {24'hFC1234, 16'h1234, 2'd0},
    {24'h03A5C3, 16'hA5C3, 2'd3},
    {24'h000001, 16'h0001, 2'd0}
  };

  always @(posedge clk) begin
    if (rstN) begin
      if (updateStb) updCnt++;
      if (abortStb) abtCnt++;
      if (updateStb && abortStb) begin
        errors++;
        $display("FAIL R8: strobes together update=%0b abort=%0b expected not both", updateStb, abortStb);
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  // Send the first nBits of frame (MSB first), then extra falling edges, then release sync
  task automatic sendFrame(logic [23:0] frame, int nBits, int extra);
    syncN = 1'b0;
    waitClk(8);
    for (int i = 0; i < nBits + extra; i++) begin
      din = (i < nBits) ? frame[23-i] : ~din;
      waitClk(4);
      sclk = 1'b0;
      waitClk(4);
      sclk = 1'b1;
    end
    waitClk(6);
    syncN = 1'b1;
    waitClk(14);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int u0, a0;
    waitClk(3);
    // R1 reset state
    check("R1 code", dacCode, 16'h0000);
    check("R1 mode", pwrMode, 2'b00);
    check("R1 strobes", {updateStb, abortStb}, 2'b00);
    rstN = 1'b1;
    waitClk(5);
    check("R1 code after release", dacCode, 16'h0000);

    // R2/R3 table of complete frames
    for (int v = 0; v < NVEC; v++) begin
      u0 = updCnt;
      sendFrame(VEC[v][41:18], 24, 0);
      check("R2 code", dacCode, VEC[v][17:2]);
      check("R2 mode", pwrMode, VEC[v][1:0]);
      check("R3 one update", updCnt - u0, 1);
    end

    // R4 abort after 10 bits, and at the boundary after 23 bits
    u0 = updCnt; a0 = abtCnt;
    sendFrame(24'h03BEEF, 10, 0);
    check("R4 code held", dacCode, 16'h0001);
    check("R4 mode held", pwrMode, 2'd0);
    check("R4 abort pulse", abtCnt - a0, 1);
    check("R4 no update", updCnt - u0, 0);
    u0 = updCnt; a0 = abtCnt;
    sendFrame(24'h02CAFE, 23, 0);
    check("R4 23-bit code held", dacCode, 16'h0001);
    check("R4 23-bit abort", abtCnt - a0, 1);
    check("R4 23-bit no update", updCnt - u0, 0);

    // R7 full frame right after an abort
    u0 = updCnt;
    sendFrame(24'h015A5A, 24, 0);
    check("R7 code", dacCode, 16'h5A5A);
    check("R7 mode", pwrMode, 2'd1);
    check("R7 one update", updCnt - u0, 1);

    // R5 extra edges after the 24th
    u0 = updCnt; a0 = abtCnt;
    sendFrame(24'h00C001, 24, 5);
    check("R5 code", dacCode, 16'hC001);
    check("R5 mode", pwrMode, 2'd0);
    check("R5 single update", updCnt - u0, 1);
    check("R5 no abort", abtCnt - a0, 0);

    // R6 clock toggling with sync high
    u0 = updCnt; a0 = abtCnt;
    din = 1'b1;
    for (int i = 0; i < 30; i++) begin
      waitClk(4); sclk = 1'b0; waitClk(4); sclk = 1'b1;
    end
    waitClk(10);
    check("R6 code", dacCode, 16'hC001);
    check("R6 mode", pwrMode, 2'd0);
    check("R6 no strobes", (updCnt - u0) + (abtCnt - a0), 0);

    // R1 reset again mid-life returns to midscale
    rstN = 1'b0;
    waitClk(2);
    check("R1 re-reset code", dacCode, 16'h0000);
    check("R1 re-reset mode", pwrMode, 2'd0);
    rstN = 1'b1;
    waitClk(4);
    finishRun();
  end
endmodule